// File: doc/BRIEF.md
# Register-Controlled Serial Peripheral Master

The block is a serial peripheral interface master that software drives through a small 32-bit register slave with a 5-bit byte address. Each request is acknowledged after one cycle. Software sets up a transfer before starting it. It loads the transmit word and picks a frame of 8, 16 or 32 bits. It chooses the bit order and selects which serial clock edge moves the outgoing line and which edge samples the incoming line. It also sets the clock divider and the slave-select pattern.

Setting the go bit in the control register starts the transfer. That bit reads back as busy until the last bit has moved. At the end of the frame the received word is available at the data address and the interrupt output rises. Reading the data address clears the interrupt again.

The serial clock rests low between transfers. The active-low select lines follow the select register only while a transfer runs.

Top module: `spi_master_ctrl`

## Requirements
- R1: Byte address 0x0 is data: a write loads the transmit word and a read returns the receive word. Address 0x4 is control, 0x8 is the clock divider and 0xC is slave select. Address bits [4:2] decode the register. Control readback holds bits 0, 1, 2, 6, 7, 8 and 9, and every other bit reads 0. Each accepted request raises bus_ack_o for exactly one cycle, one clock later, and read data is valid while bus_ack_o is high.
- R2: Writing 1 to control bit 0 while idle starts a transfer. Control bit 0 then reads 1 until the transfer ends and returns to 0 by itself.
- R3: sclk_o is low whenever no transfer runs. During a transfer its period is 2 × (divider + 1) clocks, so a divider of 5 gives 12 clocks.
- R4: With control bit 2 clear, mosi_o moves on rising sclk edges, and bit k appears at rising edge k+1. With bit 2 set, the first bit is on mosi_o before the first edge and each later bit appears on a falling edge.
- R5: With control bit 1 clear, miso_i is sampled on each rising sclk edge. With bit 1 set, it is sampled on each falling edge. Exactly one sample is taken per frame bit.
- R6: With control bit 8 clear, the word goes out and is assembled most significant bit first. With bit 8 set, least significant bit first.
- R7: The frame is 32 bits if control bit 9 is set, otherwise 16 bits if bit 7 is set, otherwise 8 bits. The received bits occupy the low bits of the receive word, and the upper bits read 0.
- R8: The slave-select register reads back as written and may be written at any time. sel_n_o is the inverse of that register while a transfer runs and all ones otherwise.
- R9: irq_o rises when a transfer completes. It is low in the cycle after a read of the data address has been accepted.
- R10: While busy, writes to the data, control and divider addresses change nothing. In particular, the go bit cannot be cleared.
- R11: After reset, every register reads 0, irq_o and sclk_o are low and sel_n_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_adr_i | input | 5 | Byte address of the register access |
| bus_dat_i | input | 32 | Write data |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_stb_i | input | 1 | Access strobe |
| bus_cyc_i | input | 1 | Bus cycle in progress |
| bus_dat_o | output | 32 | Read data, valid with bus_ack_o |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| irq_o | output | 1 | Transfer-complete interrupt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sel_n_o | output | 8 | Active-low slave selects |

## Verification
A behavioural slave in the bench drives miso_i from a random word and records mosi_o. It uses edge settings that match the master's. Random transfers cover all four edge pairings, both bit orders, all three frame lengths and divider values from 0 to 3. In each one the outgoing word, the incoming word and the serial data all take fresh random values. A wrong launch or sample edge then shows up as a missing or shifted bit, a wrong order as a mirrored word, and a wrong length as a bad bit count or a dirty upper half. Directed cases add four checks: the 12-clock period at divider 5, length selection when several length bits or none are set, writes during a transfer, and select outputs that stay high while idle.

// File: rtl/spi_master_pkg.sv
`timescale 1ns/1ps
package spi_master_pkg;
  parameter int XFER_W = 32;
  parameter int IDX_W  = $clog2(XFER_W);

  localparam int CTL_GO      = 0;
  localparam int CTL_RX_FALL = 1;
  localparam int CTL_TX_FALL = 2;
  localparam int CTL_LEN8    = 6;
  localparam int CTL_LEN16   = 7;
  localparam int CTL_LSB     = 8;
  localparam int CTL_LEN32   = 9;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_DIV  = 3'd2;
  localparam logic [2:0] A_SEL  = 3'd3;

  typedef enum logic [1:0] {LEN_8, LEN_16, LEN_32} frame_len_e;

  typedef struct packed {
    logic       lsb_first;
    frame_len_e len;
    logic       tx_fall;
    logic       rx_fall;
  } xfer_cfg_t;

  function automatic logic [IDX_W-1:0] msb_index(frame_len_e l);
    case (l)
      LEN_16:  return IDX_W'(15);
      LEN_32:  return IDX_W'(31);
      default: return IDX_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/spi_reg_if.sv
`timescale 1ns/1ps
module spi_reg_if
  import spi_master_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int SEL_N  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] wdat_i,
  input  logic              we_i,
  input  logic              stb_i,
  input  logic              cyc_i,
  output logic [DATA_W-1:0] rdat_o,
  output logic              ack_o,
  output logic              irq_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [XFER_W-1:0] rx_i,
  output logic              start_o,
  output xfer_cfg_t         cfg_o,
  output logic [XFER_W-1:0] tx_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [SEL_N-1:0]  sel_o
);
  logic              ack_q, start_q, irq_q;
  logic [DATA_W-1:0] rdat_q;
  logic [XFER_W-1:0] tx_q;
  logic [DIV_W-1:0]  div_q;
  logic [SEL_N-1:0]  sel_q;
  logic              rx_fall_q, tx_fall_q, lsb_q, l8_q, l16_q, l32_q;
  logic              req, wr, rd, busy_any;
  logic [2:0]        reg_idx;
  logic [DATA_W-1:0] ctrl_rd;

  assign req      = stb_i && cyc_i && !ack_q;
  assign wr       = req && we_i;
  assign rd       = req && !we_i;
  assign reg_idx  = adr_i[4:2];
  assign busy_any = busy_i || start_q;

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CTL_GO]      = busy_any;
    ctrl_rd[CTL_RX_FALL] = rx_fall_q;
    ctrl_rd[CTL_TX_FALL] = tx_fall_q;
    ctrl_rd[CTL_LEN8]    = l8_q;
    ctrl_rd[CTL_LEN16]   = l16_q;
    ctrl_rd[CTL_LSB]     = lsb_q;
    ctrl_rd[CTL_LEN32]   = l32_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0; start_q <= 1'b0; irq_q <= 1'b0; rdat_q <= '0;
      tx_q <= '0; div_q <= '0; sel_q <= '0;
      rx_fall_q <= 1'b0; tx_fall_q <= 1'b0; lsb_q <= 1'b0;
      l8_q <= 1'b0; l16_q <= 1'b0; l32_q <= 1'b0;
    end else begin
      ack_q   <= req;
      start_q <= 1'b0;
      if (wr && !busy_any) begin
        case (reg_idx)
          A_DATA: tx_q <= wdat_i[XFER_W-1:0];
          A_CTRL: begin
            rx_fall_q <= wdat_i[CTL_RX_FALL];
            tx_fall_q <= wdat_i[CTL_TX_FALL];
            l8_q      <= wdat_i[CTL_LEN8];
            l16_q     <= wdat_i[CTL_LEN16];
            lsb_q     <= wdat_i[CTL_LSB];
            l32_q     <= wdat_i[CTL_LEN32];
            start_q   <= wdat_i[CTL_GO];
          end
          A_DIV:   div_q <= wdat_i[DIV_W-1:0];
          default: ;
        endcase
      end
      if (wr && reg_idx == A_SEL) sel_q <= wdat_i[SEL_N-1:0];
      if (rd) begin
        case (reg_idx)
          A_DATA:  rdat_q <= DATA_W'(rx_i);
          A_CTRL:  rdat_q <= ctrl_rd;
          A_DIV:   rdat_q <= DATA_W'(div_q);
          A_SEL:   rdat_q <= DATA_W'(sel_q);
          default: rdat_q <= '0;
        endcase
      end
      if (done_i)                        irq_q <= 1'b1;
      else if (rd && reg_idx == A_DATA) irq_q <= 1'b0;
    end
  end

  assign rdat_o        = rdat_q;
  assign ack_o         = ack_q;
  assign irq_o         = irq_q;
  assign start_o       = start_q;
  assign tx_o          = tx_q;
  assign div_o         = div_q;
  assign sel_o         = sel_q;
  assign cfg_o.rx_fall   = rx_fall_q;
  assign cfg_o.tx_fall   = tx_fall_q;
  assign cfg_o.lsb_first = lsb_q;
  assign cfg_o.len       = l32_q ? LEN_32 : (l16_q ? LEN_16 : LEN_8);

  assert_ack_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  assert_irq_clear_by_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(rd && reg_idx == A_DATA));
  assert_irq_set_by_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(done_i));
  assert_div_frozen_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(div_q));
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0; sclk_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0; sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;

  assert_sclk_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !sclk_q);
  assert_sclk_moves_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q != $past(sclk_q)) |-> $past(tick_o));
endmodule

// File: rtl/spi_shift_eng.sv
`timescale 1ns/1ps
module spi_shift_eng
  import spi_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  xfer_cfg_t         cfg_i,
  input  logic [XFER_W-1:0] tx_data_i,
  input  logic              tick_i,
  input  logic              sclk_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mosi_o,
  output logic [XFER_W-1:0] rx_data_o
);
  localparam int CNT_W = IDX_W + 1;

  logic              busy_q, done_q, mosi_q;
  logic [XFER_W-1:0] sh_tx_q, sh_rx_q, rx_q;
  logic [CNT_W-1:0]  edge_q;
  logic [IDX_W-1:0]  msb_idx;
  logic [XFER_W-1:0] tx_src, tx_nx, rx_dn, rx_lsb, rx_msb, rx_nx;
  logic              tx_bit, is_rise, smp_now, drv_now, last;

  assign msb_idx = msb_index(cfg_i.len);
  assign tx_src  = busy_q ? sh_tx_q : tx_data_i;
  assign tx_bit  = cfg_i.lsb_first ? tx_src[0] : tx_src[msb_idx];
  assign tx_nx   = cfg_i.lsb_first ? (tx_src >> 1) : (tx_src << 1);

  assign rx_dn  = sh_rx_q >> 1;
  assign rx_msb = {sh_rx_q[XFER_W-2:0], miso_i};
  always_comb begin
    rx_lsb = '0;
    for (int i = 0; i < XFER_W; i++) begin
      if (IDX_W'(i) == msb_idx)     rx_lsb[i] = miso_i;
      else if (IDX_W'(i) < msb_idx) rx_lsb[i] = rx_dn[i];
    end
  end
  assign rx_nx = cfg_i.lsb_first ? rx_lsb : rx_msb;

  assign is_rise = !sclk_i;
  assign smp_now = is_rise ^ cfg_i.rx_fall;
  assign drv_now = is_rise ^ cfg_i.tx_fall;
  assign last    = (edge_q == {msb_idx, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; mosi_q <= 1'b0;
      sh_tx_q <= '0; sh_rx_q <= '0; rx_q <= '0; edge_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        edge_q  <= '0;
        sh_rx_q <= '0;
        if (cfg_i.tx_fall) begin
          mosi_q  <= tx_bit;  // first bit leads the first edge
          sh_tx_q <= tx_nx;
        end else begin
          sh_tx_q <= tx_data_i;
        end
      end else if (busy_q && tick_i) begin
        edge_q <= edge_q + 1'b1;
        if (smp_now) sh_rx_q <= rx_nx;
        if (drv_now && !last) begin
          mosi_q  <= tx_bit;
          sh_tx_q <= tx_nx;
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= smp_now ? rx_nx : sh_rx_q;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mosi_o    = mosi_q;
  assign rx_data_o = rx_q;

  assert_done_at_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  assert_edge_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (edge_q <= {msb_idx, 1'b1}));
endmodule

// File: rtl/spi_master_ctrl.sv
`timescale 1ns/1ps
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int SEL_N  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_adr_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  input  logic              bus_we_i,
  input  logic              bus_stb_i,
  input  logic              bus_cyc_i,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              bus_ack_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [SEL_N-1:0]  sel_n_o
);
  logic              start, busy, done, tick, sclk;
  xfer_cfg_t         cfg;
  logic [XFER_W-1:0] tx_data, rx_data;
  logic [DIV_W-1:0]  div;
  logic [SEL_N-1:0]  sel;

  spi_reg_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_N(SEL_N)) u_regs (
    .clk_i, .rst_ni,
    .adr_i(bus_adr_i), .wdat_i(bus_dat_i), .we_i(bus_we_i), .stb_i(bus_stb_i), .cyc_i(bus_cyc_i),
    .rdat_o(bus_dat_o), .ack_o(bus_ack_o), .irq_o(irq_o),
    .busy_i(busy), .done_i(done), .rx_i(rx_data),
    .start_o(start), .cfg_o(cfg), .tx_o(tx_data), .div_o(div), .sel_o(sel)
  );

  spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div), .tick_o(tick), .sclk_o(sclk)
  );

  spi_shift_eng u_eng (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(cfg), .tx_data_i(tx_data),
    .tick_i(tick), .sclk_i(sclk), .miso_i(miso_i),
    .busy_o(busy), .done_o(done), .mosi_o(mosi_o), .rx_data_o(rx_data)
  );

  assign sclk_o  = sclk;
  assign sel_n_o = busy ? ~sel : '1;

  assert_done_sclk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !sclk);
  assert_irq_follows_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> irq_o);
endmodule

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb;
  localparam logic [4:0] AD_DATA = 5'h00, AD_CTRL = 5'h04, AD_DIV = 5'h08, AD_SEL = 5'h0C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  adr = '0;
  logic [31:0] wdat = '0, rdat;
  logic        we = 1'b0, stb = 1'b0, cyc = 1'b0, ack, irq, sclk, mosi, miso = 1'b0;
  logic [7:0]  sel_n;
  int          n_chk = 0, n_err = 0;

  // slave model state
  logic        sl_rx_fall = 1'b0, sl_tx_fall = 1'b0;
  logic [31:0] sl_word = '0, m_cap = '0;
  int          cap_n = 0, drv_k = 0;
  logic        in_x = 1'b0, sel_prev = 1'b1, sclk_prev = 1'b0;

  always #4 clk = ~clk;

  spi_master_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_we_i(we),
    .bus_stb_i(stb), .bus_cyc_i(cyc), .bus_dat_o(rdat), .bus_ack_o(ack), .irq_o(irq),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .sel_n_o(sel_n)
  );

  always @(sclk or sel_n[0]) begin
    if (sel_n[0] != sel_prev && !sel_n[0]) begin
      in_x = 1'b1; cap_n = 0; m_cap = '0; drv_k = 0; miso = sl_word[0];
    end
    if (sclk != sclk_prev && in_x) begin
      if (sclk == sl_tx_fall && cap_n < 32) begin m_cap[cap_n] = mosi; cap_n++; end
      if (sclk == sl_rx_fall) begin
        if (!sl_rx_fall) begin drv_k++; if (drv_k < 32) miso = sl_word[drv_k]; end
        else begin if (drv_k < 32) miso = sl_word[drv_k]; drv_k++; end
      end
    end
    if (sel_n[0] != sel_prev && sel_n[0]) in_x = 1'b0;
    sel_prev = sel_n[0]; sclk_prev = sclk;
  end

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); adr = a; wdat = d; we = 1'b1; stb = 1'b1; cyc = 1'b1;
    @(negedge clk); chk_eq("R1 write ack", 32'(ack), 1);
    stb = 1'b0; cyc = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); adr = a; we = 1'b0; stb = 1'b1; cyc = 1'b1;
    @(negedge clk); d = rdat; stb = 1'b0; cyc = 1'b0;
  endtask

  function automatic int frame_n(input logic [31:0] c);
    return c[9] ? 32 : (c[7] ? 16 : 8);
  endfunction

  function automatic logic [31:0] exp_line(input logic [31:0] tx, input int n, input logic lsb);
    logic [31:0] r = '0;
    for (int j = 0; j < n; j++) r[j] = lsb ? tx[j] : tx[n-1-j];
    return r;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] w, input int n, input logic lsb);
    logic [31:0] r = '0;
    for (int j = 0; j < n; j++) if (lsb) r[j] = w[j]; else r[n-1-j] = w[j];
    return r;
  endfunction

  task automatic wait_idle();
    logic [31:0] v = 32'h1;
    for (int k = 0; k < 20000 && v[0]; k++) bus_rd(AD_CTRL, v);
    chk_eq("R2 busy clears", v & 32'h1, 0);
  endtask

  task automatic go(input logic [31:0] fields, input logic [15:0] dv);
    sl_rx_fall = fields[1]; sl_tx_fall = fields[2];
    bus_wr(AD_DIV, 32'(dv));
    bus_wr(AD_CTRL, fields & ~32'h1);
    bus_wr(AD_CTRL, fields | 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, tx, fields;
    time t0, t1;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_eq("R11 sclk low", 32'(sclk), 0);
    chk_eq("R11 irq low", 32'(irq), 0);
    chk_eq("R11 sel_n high", 32'(sel_n), 32'hFF);
    rst_n = 1'b1;
    bus_rd(AD_CTRL, v); chk_eq("R11 ctrl", v, 0);
    bus_rd(AD_DIV, v);  chk_eq("R11 div", v, 0);
    bus_rd(AD_SEL, v);  chk_eq("R11 sel", v, 0);
    bus_rd(AD_DATA, v); chk_eq("R11 data", v, 0);
    @(negedge clk); chk_eq("R1 ack single", 32'(ack), 0);

    // R1 and R8 register readback while idle
    bus_wr(AD_SEL, 32'hA5);
    bus_rd(AD_SEL, v); chk_eq("R8 sel readback", v, 32'hA5);
    chk_eq("R8 sel_n idle high", 32'(sel_n), 32'hFF);
    bus_wr(AD_DIV, 32'd5);
    bus_rd(AD_DIV, v); chk_eq("R1 div readback", v, 5);
    bus_wr(AD_CTRL, 32'h346);
    bus_rd(AD_CTRL, v); chk_eq("R1 ctrl readback", v, 32'h346);
    bus_wr(AD_CTRL, 32'h38);
    bus_rd(AD_CTRL, v); chk_eq("R1 unused ctrl bits", v, 0);

    // R2 R3 R8 directed 8-bit transfer, divider 5
    sl_word = $urandom;
    bus_wr(AD_DATA, 32'h5A);
    go(32'h40, 16'd5);
    bus_rd(AD_CTRL, v); chk_eq("R2 busy reads 1", v, 32'h41);
    chk_eq("R8 sel_n active", 32'(sel_n), 32'h5A);
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk_eq("R3 sclk period", 32'((t1 - t0) / 8), 12);
    wait_idle();
    chk_eq("R8 sel_n released", 32'(sel_n), 32'hFF);
    chk_eq("R3 sclk idle", 32'(sclk), 0);
    chk_eq("R4 mosi msb", m_cap, exp_line(32'h5A, 8, 1'b0));
    chk_eq("R9 irq set", 32'(irq), 1);
    bus_rd(AD_DATA, v); chk_eq("R5 rx", v, exp_rx(sl_word, 8, 1'b0));
    chk_eq("R9 irq cleared", 32'(irq), 0);
    bus_wr(AD_SEL, 32'h01);

    // R10 writes ignored while busy
    tx = 32'hC3A50F96; sl_word = $urandom;
    bus_wr(AD_DATA, tx);
    go(32'h200, 16'd7);
    bus_wr(AD_DATA, 32'h11111111);
    bus_wr(AD_DIV, 32'd1);
    bus_wr(AD_CTRL, 32'h0);
    bus_rd(AD_CTRL, v); chk_eq("R10 ctrl kept, go held", v, 32'h201);
    bus_rd(AD_DIV, v);  chk_eq("R10 div kept", v, 7);
    wait_idle();
    bus_rd(AD_DATA, v);
    chk_eq("R10 mosi from original word", m_cap, exp_line(tx, 32, 1'b0));
    bus_wr(AD_CTRL, 32'h201);
    wait_idle();
    bus_rd(AD_DATA, v);
    chk_eq("R10 tx register unchanged", m_cap, exp_line(tx, 32, 1'b0));

    // R7 length priority
    bus_wr(AD_DATA, $urandom);
    go(32'hC0, 16'd0); wait_idle(); bus_rd(AD_DATA, v);
    chk_eq("R7 bits 6+7 give 16", 32'(cap_n), 16);
    go(32'h0, 16'd0); wait_idle(); bus_rd(AD_DATA, v);
    chk_eq("R7 no length bit gives 8", 32'(cap_n), 8);
    go(32'h2C0, 16'd0); wait_idle(); bus_rd(AD_DATA, v);
    chk_eq("R7 bit 9 wins", 32'(cap_n), 32);

    // random transfers: R4 R5 R6 R7 R9
    for (int it = 0; it < 28; it++) begin
      tx = $urandom; sl_word = $urandom;
      fields = 32'((1 << (6 + ($urandom % 3))));
      if (fields == 32'h100) fields = 32'h200;
      fields = fields | (32'($urandom % 2) << 8) | (32'($urandom % 2) << 1) | (32'($urandom % 2) << 2);
      n = frame_n(fields);
      bus_wr(AD_DATA, tx);
      go(fields, 16'($urandom % 4));
      wait_idle();
      chk_eq("R9 irq on completion", 32'(irq), 1);
      chk_eq("R7 bit count", 32'(cap_n), 32'(n));
      chk_eq("R4 R6 mosi sequence", m_cap, exp_line(tx, n, fields[8]));
      bus_rd(AD_DATA, v);
      chk_eq("R5 R6 R7 received word", v, exp_rx(sl_word, n, fields[8]));
      chk_eq("R9 irq after read", 32'(irq), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule